// File: doc/BRIEF.md
# DES Single-Round Command Unit

This block is a DES datapath that sits beside a processor and executes instruction-style commands. A key-load command turns a 64-bit key, given as two 32-bit operands, into two 28-bit key halves. A data-load command stores a 64-bit block in a 64-bit data register. A readback command returns one 32-bit half of the block. A round command performs exactly one DES round. The unit never sequences rounds by itself. A small controller or firmware loop issues sixteen round commands, and each command's 2-bit immediate selects the direction and the key rotation amount for that round.

The data register holds the block in the internal left/right form. The initial permutation is applied when the block is loaded. The final permutation, together with the closing swap of the halves, is applied on the readback path. After sixteen rounds, a readback therefore returns the finished DES result directly. An encrypt round rotates the key halves left first and then derives its subkey from them. A decrypt round derives its subkey from the present halves and then rotates them right. Either sixteen-round sequence therefore ends with the key halves back where they started.

Top module: `des_round_unit`

## Requirements
- R1: After reset, round_done and rd_valid are low, rd_data is zero, and the key halves and data register are all zero, so a readback before any load returns zero.
- R2: Key load (cmd_op = 0) applies permuted choice 1 to {opnd_hi, opnd_lo}, with opnd_hi as the upper word. The least significant bit of every key byte has no effect on any later result.
- R3: Data load (cmd_op = 1) stores the initial permutation of {opnd_hi, opnd_lo}, with opnd_hi as the upper word.
- R4: Readback (cmd_op = 2) raises rd_valid one clock after the command. rd_data then carries the upper 32 bits of the output word when cmd_imm[0] = 1, and the lower 32 bits when it is 0. The output word is the final permutation of the swapped halves. A readback leaves all state unchanged.
- R5: Round (cmd_op = 3) uses cmd_imm[1] as the direction (0 encrypt, 1 decrypt) and cmd_imm[0] as the rotation (0 rotate by 1, 1 rotate by 2). The immediate values 0 to 3 therefore mean encrypt/1, encrypt/2, decrypt/1 and decrypt/2.
- R6: An encrypt round rotates both key halves left before forming the 48-bit subkey. A decrypt round forms the subkey first and then rotates both halves right.
- R7: A key load, a data load and sixteen encrypt rounds (rotate by 1 in rounds 0, 1, 8 and 15, by 2 otherwise) produce the standard DES ciphertext on readback.
- R8: Sixteen decrypt rounds using the reversed rotation schedule recover the plaintext from the ciphertext.
- R9: round_done pulses high for exactly the one clock after each round command, and at no other time.
- R10: After a complete sixteen-round sequence in either direction, the key halves equal their values after the key load, so another block can be processed without reloading the key.
- R11: While cmd_valid is low, no register changes, whatever the other inputs hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 2 | 0 key load, 1 data load, 2 readback, 3 round |
| cmd_imm | input | 2 | Readback half select (bit 0) or round mode |
| opnd_hi | input | 32 | Upper operand word |
| opnd_lo | input | 32 | Lower operand word |
| rd_data | output | 32 | Readback result |
| rd_valid | output | 1 | rd_data is valid |
| round_done | output | 1 | A round command completed |

## Verification
The hardest state to reach from the ports is the key halves after a full round sequence. They cannot be read back, and an error in them shows up only in the next block processed under the same key. The stimulus therefore decrypts each ciphertext right after encrypting it, without reloading the key. It also issues an encrypt round and then a decrypt round with the same rotation before a full known-answer encryption. Any wrong rotation direction, or a subkey formed on the wrong side of the rotation, corrupts that later result. Parity-only key changes and commands presented with cmd_valid low are checked the same way, by comparing a later readback against the expected value.

// File: rtl/des_pkg.sv
package des_pkg;

   typedef enum logic [1:0] {
      OP_KEY   = 2'd0,
      OP_DATA  = 2'd1,
      OP_READ  = 2'd2,
      OP_ROUND = 2'd3
   } des_op_e;

   localparam int KEY_SEL_T [0:55] = '{
      57,49,41,33,25,17, 9, 1,58,50,42,34,26,18,
      10, 2,59,51,43,35,27,19,11, 3,60,52,44,36,
      63,55,47,39,31,23,15, 7,62,54,46,38,30,22,
      14, 6,61,53,45,37,29,21,13, 5,28,20,12, 4};

   localparam int SUB_SEL_T [0:47] = '{
      14,17,11,24, 1, 5, 3,28,15, 6,21,10,
      23,19,12, 4,26, 8,16, 7,27,20,13, 2,
      41,52,31,37,47,55,30,40,51,45,33,48,
      44,49,39,56,34,53,46,42,50,36,29,32};

   localparam int MIX_T [0:31] = '{
      16, 7,20,21,29,12,28,17, 1,15,23,26, 5,18,31,10,
       2, 8,24,14,32,27, 3, 9,19,13,30, 6,22,11, 4,25};

   localparam logic [3:0] SB0_T [0:63] = '{
      14, 4,13, 1, 2,15,11, 8, 3,10, 6,12, 5, 9, 0, 7,
       0,15, 7, 4,14, 2,13, 1,10, 6,12,11, 9, 5, 3, 8,
       4, 1,14, 8,13, 6, 2,11,15,12, 9, 7, 3,10, 5, 0,
      15,12, 8, 2, 4, 9, 1, 7, 5,11, 3,14,10, 0, 6,13};
   localparam logic [3:0] SB1_T [0:63] = '{
      15, 1, 8,14, 6,11, 3, 4, 9, 7, 2,13,12, 0, 5,10,
       3,13, 4, 7,15, 2, 8,14,12, 0, 1,10, 6, 9,11, 5,
       0,14, 7,11,10, 4,13, 1, 5, 8,12, 6, 9, 3, 2,15,
      13, 8,10, 1, 3,15, 4, 2,11, 6, 7,12, 0, 5,14, 9};
   localparam logic [3:0] SB2_T [0:63] = '{
      10, 0, 9,14, 6, 3,15, 5, 1,13,12, 7,11, 4, 2, 8,
      13, 7, 0, 9, 3, 4, 6,10, 2, 8, 5,14,12,11,15, 1,
      13, 6, 4, 9, 8,15, 3, 0,11, 1, 2,12, 5,10,14, 7,
       1,10,13, 0, 6, 9, 8, 7, 4,15,14, 3,11, 5, 2,12};
   localparam logic [3:0] SB3_T [0:63] = '{
       7,13,14, 3, 0, 6, 9,10, 1, 2, 8, 5,11,12, 4,15,
      13, 8,11, 5, 6,15, 0, 3, 4, 7, 2,12, 1,10,14, 9,
      10, 6, 9, 0,12,11, 7,13,15, 1, 3,14, 5, 2, 8, 4,
       3,15, 0, 6,10, 1,13, 8, 9, 4, 5,11,12, 7, 2,14};
   localparam logic [3:0] SB4_T [0:63] = '{
       2,12, 4, 1, 7,10,11, 6, 8, 5, 3,15,13, 0,14, 9,
      14,11, 2,12, 4, 7,13, 1, 5, 0,15,10, 3, 9, 8, 6,
       4, 2, 1,11,10,13, 7, 8,15, 9,12, 5, 6, 3, 0,14,
      11, 8,12, 7, 1,14, 2,13, 6,15, 0, 9,10, 4, 5, 3};
   localparam logic [3:0] SB5_T [0:63] = '{
      12, 1,10,15, 9, 2, 6, 8, 0,13, 3, 4,14, 7, 5,11,
      10,15, 4, 2, 7,12, 9, 5, 6, 1,13,14, 0,11, 3, 8,
       9,14,15, 5, 2, 8,12, 3, 7, 0, 4,10, 1,13,11, 6,
       4, 3, 2,12, 9, 5,15,10,11,14, 1, 7, 6, 0, 8,13};
   localparam logic [3:0] SB6_T [0:63] = '{
       4,11, 2,14,15, 0, 8,13, 3,12, 9, 7, 5,10, 6, 1,
      13, 0,11, 7, 4, 9, 1,10,14, 3, 5,12, 2,15, 8, 6,
       1, 4,11,13,12, 3, 7,14,10,15, 6, 8, 0, 5, 9, 2,
       6,11,13, 8, 1, 4,10, 7, 9, 5, 0,15,14, 2, 3,12};
   localparam logic [3:0] SB7_T [0:63] = '{
      13, 2, 8, 4, 6,15,11, 1,10, 9, 3,14, 5, 0,12, 7,
       1,15,13, 8,10, 3, 7, 4,12, 5, 6,11, 0,14, 9, 2,
       7,11, 4, 1, 9,12,14, 2, 0, 6,10,13,15, 3, 5, 8,
       2, 1,14, 7, 4,10, 8,13,15,12, 9, 0, 3, 5, 6,11};

   // source bit (1 = most significant) of the block entry permutation
   function automatic int entry_src(input int j);
      int row;
      row = j / 8;
      return ((row < 4) ? (58 + 2 * row) : (57 + 2 * (row - 4))) - 8 * (j % 8);
   endfunction

   function automatic logic [63:0] entry_perm(input logic [63:0] x);
      logic [63:0] y;
      y = '0;
      for (int j = 0; j < 64; j++) y[63 - j] = x[64 - entry_src(j)];
      return y;
   endfunction

   function automatic logic [63:0] exit_perm(input logic [63:0] x);
      logic [63:0] y;
      y = '0;
      for (int j = 0; j < 64; j++) y[64 - entry_src(j)] = x[63 - j];
      return y;
   endfunction

   function automatic logic [47:0] widen(input logic [31:0] x);
      logic [47:0] y;
      int src;
      y = '0;
      for (int g = 0; g < 8; g++)
         for (int t = 0; t < 6; t++) begin
            src = ((4 * g + t - 1 + 32) % 32) + 1;
            y[47 - (6 * g + t)] = x[32 - src];
         end
      return y;
   endfunction

   function automatic logic [55:0] key_select(input logic [63:0] x);
      logic [55:0] y;
      y = '0;
      for (int j = 0; j < 56; j++) y[55 - j] = x[64 - KEY_SEL_T[j]];
      return y;
   endfunction

   function automatic logic [47:0] sub_select(input logic [55:0] x);
      logic [47:0] y;
      y = '0;
      for (int j = 0; j < 48; j++) y[47 - j] = x[56 - SUB_SEL_T[j]];
      return y;
   endfunction

   function automatic logic [31:0] mix_perm(input logic [31:0] x);
      logic [31:0] y;
      y = '0;
      for (int j = 0; j < 32; j++) y[31 - j] = x[32 - MIX_T[j]];
      return y;
   endfunction

endpackage

// File: rtl/des_sbox.sv
module des_sbox #(
   parameter int BOX = 0
) (
   input  logic [5:0] sel,
   output logic [3:0] val
);
   import des_pkg::*;

   logic [5:0] addr;
   assign addr = {sel[5], sel[0], sel[4:1]};

   generate
      if (BOX == 0)      begin : g_b0 assign val = SB0_T[addr]; end
      else if (BOX == 1) begin : g_b1 assign val = SB1_T[addr]; end
      else if (BOX == 2) begin : g_b2 assign val = SB2_T[addr]; end
      else if (BOX == 3) begin : g_b3 assign val = SB3_T[addr]; end
      else if (BOX == 4) begin : g_b4 assign val = SB4_T[addr]; end
      else if (BOX == 5) begin : g_b5 assign val = SB5_T[addr]; end
      else if (BOX == 6) begin : g_b6 assign val = SB6_T[addr]; end
      else if (BOX == 7) begin : g_b7 assign val = SB7_T[addr]; end
      else begin : g_bad
         $error("des_sbox: BOX must be 0..7");
         assign val = '0;
      end
   endgenerate
endmodule

// File: rtl/des_feistel.sv
module des_feistel #(
   parameter int HALF_W   = 32,
   parameter int SUBKEY_W = 48,
   parameter int N_BOX    = 8
) (
   input  logic [HALF_W-1:0]   rhalf,
   input  logic [SUBKEY_W-1:0] subkey,
   output logic [HALF_W-1:0]   fout
);
   import des_pkg::*;

   localparam int IDX_W = SUBKEY_W / N_BOX;
   localparam int VAL_W = HALF_W / N_BOX;

   generate
      if (HALF_W != 32 || SUBKEY_W != 48 || N_BOX != 8) begin : g_bad
         $error("des_feistel: widths fixed by the cipher");
      end
   endgenerate

   logic [SUBKEY_W-1:0] mixed;
   logic [HALF_W-1:0]   subst;

   assign mixed = widen(rhalf) ^ subkey;

   generate
      for (genvar g = 0; g < N_BOX; g++) begin : g_box
         des_sbox #(.BOX(g)) u_sbox (
            .sel (mixed[SUBKEY_W-1-IDX_W*g -: IDX_W]),
            .val (subst[HALF_W-1-VAL_W*g -: VAL_W])
         );
      end
   endgenerate

   assign fout = mix_perm(subst);
endmodule

// File: rtl/des_key_sched.sv
module des_key_sched #(
   parameter int KEY_W    = 64,
   parameter int HALF_W   = 28,
   parameter int SUBKEY_W = 48
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_en,
   input  logic [KEY_W-1:0]    key_in,
   input  logic                step_en,
   input  logic                step_dec,
   input  logic                step_rot2,
   output logic [SUBKEY_W-1:0] subkey
);
   import des_pkg::*;

   generate
      if (KEY_W != 64 || HALF_W != 28 || SUBKEY_W != 48) begin : g_bad
         $error("des_key_sched: widths fixed by the cipher");
      end
   endgenerate

   logic [HALF_W-1:0]   c_q, d_q;
   logic [2*HALF_W-1:0] selected;
   logic [HALF_W-1:0]   c_l, d_l, c_r, d_r;

   function automatic logic [HALF_W-1:0] rot_l(input logic [HALF_W-1:0] x, input logic two);
      return two ? {x[HALF_W-3:0], x[HALF_W-1:HALF_W-2]} : {x[HALF_W-2:0], x[HALF_W-1]};
   endfunction

   function automatic logic [HALF_W-1:0] rot_r(input logic [HALF_W-1:0] x, input logic two);
      return two ? {x[1:0], x[HALF_W-1:2]} : {x[0], x[HALF_W-1:1]};
   endfunction

   assign selected = key_select(key_in);
   assign c_l = rot_l(c_q, step_rot2);
   assign d_l = rot_l(d_q, step_rot2);
   assign c_r = rot_r(c_q, step_rot2);
   assign d_r = rot_r(d_q, step_rot2);

   // encrypt: rotate then select; decrypt: select then rotate back
   assign subkey = sub_select(step_dec ? {c_q, d_q} : {c_l, d_l});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_q <= '0;
         d_q <= '0;
      end else if (load_en) begin
         c_q <= selected[2*HALF_W-1:HALF_W];
         d_q <= selected[HALF_W-1:0];
      end else if (step_en) begin
         c_q <= step_dec ? c_r : c_l;
         d_q <= step_dec ? d_r : d_l;
      end
   end

   // R11: key halves only move on a load or a round
   a_r11_key_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && !step_en) |=> ($stable(c_q) && $stable(d_q)));

   // R6: a rotation by any amount never creates or destroys set bits
   a_r6_rot_weight: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !load_en) |=> ($countones({c_q, d_q}) == $countones($past({c_q, d_q}))));
endmodule

// File: rtl/des_round_unit.sv
module des_round_unit #(
   parameter int BLOCK_W  = 64,
   parameter int WORD_W   = 32,
   parameter int KHALF_W  = 28,
   parameter int SUBKEY_W = 48,
   parameter bit READ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [1:0]        cmd_imm,
   input  logic [WORD_W-1:0] opnd_hi,
   input  logic [WORD_W-1:0] opnd_lo,
   output logic [WORD_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              round_done
);
   import des_pkg::*;

   localparam int N_HALF = BLOCK_W / WORD_W;

   generate
      if (N_HALF != 2 || BLOCK_W != 64) begin : g_bad
         $error("des_round_unit: block must be two 32-bit words");
      end
   endgenerate

   logic do_key, do_data, do_read, do_round;
   assign do_key   = cmd_valid && (cmd_op == OP_KEY);
   assign do_data  = cmd_valid && (cmd_op == OP_DATA);
   assign do_read  = cmd_valid && (cmd_op == OP_READ);
   assign do_round = cmd_valid && (cmd_op == OP_ROUND);

   logic [BLOCK_W-1:0]  data_q;      // {L, R}
   logic [WORD_W-1:0]   lh, rh, fval;
   logic [SUBKEY_W-1:0] subkey;
   logic [BLOCK_W-1:0]  out_word;
   logic [WORD_W-1:0]   out_half;

   assign lh = data_q[BLOCK_W-1:WORD_W];
   assign rh = data_q[WORD_W-1:0];

   des_key_sched #(
      .KEY_W(BLOCK_W), .HALF_W(KHALF_W), .SUBKEY_W(SUBKEY_W)
   ) u_ksched (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_en   (do_key),
      .key_in    ({opnd_hi, opnd_lo}),
      .step_en   (do_round),
      .step_dec  (cmd_imm[1]),
      .step_rot2 (cmd_imm[0]),
      .subkey    (subkey)
   );

   des_feistel #(
      .HALF_W(WORD_W), .SUBKEY_W(SUBKEY_W), .N_BOX(8)
   ) u_feistel (
      .rhalf  (rh),
      .subkey (subkey),
      .fout   (fval)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        data_q <= '0;
      else if (do_data)  data_q <= entry_perm({opnd_hi, opnd_lo});
      else if (do_round) data_q <= {rh, lh ^ fval};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) round_done <= 1'b0;
      else        round_done <= do_round;
   end

   assign out_word = exit_perm({rh, lh});
   assign out_half = cmd_imm[0] ? out_word[BLOCK_W-1:WORD_W] : out_word[WORD_W-1:0];

   generate
      if (READ_REG) begin : g_rd_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rd_data  <= '0;
               rd_valid <= 1'b0;
            end else begin
               rd_valid <= do_read;
               if (do_read) rd_data <= out_half;
            end
         end

         // R4: readback answers on the following clock
         a_r4_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
            do_read |=> rd_valid);
      end else begin : g_rd_comb
         assign rd_data  = do_read ? out_half : '0;
         assign rd_valid = do_read;
      end
   endgenerate

   // R9: a pulse follows every round command
   a_r9_done_after_round: assert property (@(posedge clk) disable iff (!rst_n)
      do_round |=> round_done);

   // R9: no pulse without a round command one clock earlier
   a_r9_done_only_round: assert property (@(posedge clk) disable iff (!rst_n)
      round_done |-> $past(do_round));

   // R4: a readback leaves the data register untouched
   a_r4_read_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
      do_read |=> $stable(data_q));

   // R11: idle cycles leave the data register untouched
   a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> $stable(data_q));
endmodule

// File: tb/des_round_unit_tb.sv
module des_round_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_op = 2'd0;
   logic [1:0]  cmd_imm = 2'd0;
   logic [31:0] opnd_hi = '0;
   logic [31:0] opnd_lo = '0;
   logic [31:0] rd_data;
   logic        rd_valid;
   logic        round_done;

   int checks = 0;
   int errors = 0;
   bit ended = 1'b0;

   always #4 clk = ~clk;

   des_round_unit u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_imm(cmd_imm), .opnd_hi(opnd_hi), .opnd_lo(opnd_lo),
      .rd_data(rd_data), .rd_valid(rd_valid), .round_done(round_done)
   );

   // {key, plaintext, ciphertext}
   localparam logic [191:0] VEC [0:3] = '{
      {64'h133457799BBCDFF1, 64'h0123456789ABCDEF, 64'h85E813540F0AB405},
      {64'h0E329232EA6D0D73, 64'h8787878787878787, 64'h0000000000000000},
      {64'h0000000000000000, 64'h0000000000000000, 64'h8CA64DE9C1B123A7},
      {64'h0101010101010101, 64'h95F8A5E5DD31D900, 64'h8000000000000000}};

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // presents one command, returns after the clock that consumed it
   task automatic issue(input logic [1:0] op, input logic [1:0] imm,
                        input logic [31:0] hi, input logic [31:0] lo);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_imm = imm; opnd_hi = hi; opnd_lo = lo;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic read_block(output logic [63:0] w, output bit ok);
      ok = 1'b1;
      issue(2'd2, 2'd1, '0, '0);
      ok &= rd_valid;
      w[63:32] = rd_data;
      issue(2'd2, 2'd0, '0, '0);
      ok &= rd_valid;
      w[31:0] = rd_data;
   endtask

   function automatic bit rot_two(input int r);
      return !(r == 0 || r == 1 || r == 8 || r == 15);
   endfunction

   task automatic run_encrypt();
      for (int r = 0; r < 16; r++) issue(2'd3, {1'b0, rot_two(r)}, '0, '0);
   endtask

   task automatic run_decrypt();
      for (int r = 0; r < 16; r++) issue(2'd3, {1'b1, rot_two(15 - r)}, '0, '0);
   endtask

   initial begin
      #(8 * 150000);
      if (!ended) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [63:0] w;
      logic [63:0] key, pt, ct;
      bit ok;

      // R1: reset values
      repeat (3) @(negedge clk);
      check(!round_done && !rd_valid && rd_data == 0, "R1 reset outputs",
            {rd_data, 30'd0, rd_valid, round_done}, 64'd0);
      rst_n = 1'b1;
      read_block(w, ok);
      check(ok && w == 64'd0, "R1 zero state readback", w, 64'd0);

      // R7, R8, R10, R3, R5: known-answer table, decrypt without reloading key
      for (int v = 0; v < 4; v++) begin
         key = VEC[v][191:128]; pt = VEC[v][127:64]; ct = VEC[v][63:0];
         issue(2'd0, 2'd0, key[63:32], key[31:0]);
         issue(2'd1, 2'd0, pt[63:32], pt[31:0]);
         run_encrypt();
         read_block(w, ok);
         check(ok && w[63:32] == ct[63:32], "R7 encrypt upper", w, ct);
         check(ok && w[31:0] == ct[31:0], "R7 encrypt lower", w, ct);
         issue(2'd1, 2'd0, ct[63:32], ct[31:0]);
         run_decrypt();
         read_block(w, ok);
         check(ok && w == pt, "R8 R10 decrypt after encrypt, key kept", w, pt);
         issue(2'd1, 2'd0, pt[63:32], pt[31:0]);
         run_encrypt();
         read_block(w, ok);
         check(ok && w == ct, "R10 re-encrypt after decrypt, key kept", w, ct);
      end

      // R2: key parity bits ignored (all byte LSBs set versus clear)
      issue(2'd0, 2'd0, 32'h00000000, 32'h00000000);
      issue(2'd1, 2'd0, 32'h95F8A5E5, 32'hDD31D900);
      run_encrypt();
      read_block(w, ok);
      check(ok && w == 64'h8000000000000000, "R2 parity-cleared key", w, 64'h8000000000000000);
      issue(2'd0, 2'd0, 32'hFEFEFEFE, 32'hFEFEFEFE);
      issue(2'd0, 2'd0, 32'h01010101, 32'h01010101);
      issue(2'd1, 2'd0, 32'h95F8A5E5, 32'hDD31D900);
      run_encrypt();
      read_block(w, ok);
      check(ok && w == 64'h8000000000000000, "R2 key reload replaces halves", w, 64'h8000000000000000);

      // R6: encrypt step then decrypt step of equal rotation restores key halves
      key = VEC[0][191:128]; pt = VEC[0][127:64]; ct = VEC[0][63:0];
      issue(2'd0, 2'd0, key[63:32], key[31:0]);
      issue(2'd3, 2'd1, '0, '0);
      issue(2'd3, 2'd3, '0, '0);
      issue(2'd3, 2'd0, '0, '0);
      issue(2'd3, 2'd2, '0, '0);
      issue(2'd1, 2'd0, pt[63:32], pt[31:0]);
      run_encrypt();
      read_block(w, ok);
      check(ok && w == ct, "R6 R5 rotate order and direction", w, ct);

      // R4: readback repeated gives same value and does not disturb state
      read_block(w, ok);
      check(ok && w == ct, "R4 second readback", w, ct);

      // R11: inputs wiggling with cmd_valid low change nothing
      @(negedge clk);
      cmd_op = 2'd1; cmd_imm = 2'd3; opnd_hi = 32'hDEADBEEF; opnd_lo = 32'h12345678;
      repeat (4) @(negedge clk);
      cmd_op = 2'd3;
      repeat (4) @(negedge clk);
      cmd_op = 2'd0;
      repeat (4) @(negedge clk);
      check(!round_done && !rd_valid, "R11 no response while idle",
            {62'd0, rd_valid, round_done}, 64'd0);
      read_block(w, ok);
      check(ok && w == ct, "R11 data kept while idle", w, ct);
      issue(2'd1, 2'd0, ct[63:32], ct[31:0]);
      run_decrypt();
      read_block(w, ok);
      check(ok && w == pt, "R11 key kept while idle", w, pt);

      // R9: done timing
      issue(2'd3, 2'd0, '0, '0);
      check(round_done == 1'b1, "R9 done after round", {63'd0, round_done}, 64'd1);
      @(negedge clk);
      check(round_done == 1'b0, "R9 done single cycle", {63'd0, round_done}, 64'd0);
      issue(2'd2, 2'd0, '0, '0);
      check(round_done == 1'b0 && rd_valid, "R9 R4 no done on readback",
            {62'd0, rd_valid, round_done}, 64'd2);
      issue(2'd1, 2'd0, '0, '0);
      check(round_done == 1'b0 && !rd_valid, "R9 no done on data load",
            {62'd0, rd_valid, round_done}, 64'd0);

      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule